// File: doc/BRIEF.md
# Stacked-Cache Bank Gating Controller

This controller chooses, one evaluation interval at a time, which last-level cache banks stacked above a single core may be switched off to save leakage. It sees two streams of miss events: one from the real tag lookup and one from a shadow copy of the tags. From these it drives two masks. One mask turns off the shadow tags of a bank so that an experiment can run. The other mask enables or disables the real banks. A third output gives a one-cycle notice for each bank that has just been gated, so that surrounding logic can write back that bank's dirty lines.

After reset every bank is on and the first interval only records a baseline count of real misses. Banks are then tried one per interval. Bank index 0 is the first candidate, and the indices are arranged layer by layer, starting with the layer farthest from the heat sink. For each candidate, only the shadow tags are disabled and the shadow misses are counted over a full interval. The real bank is gated only if that count stays within a 3 % rise over the baseline. The search stops when the count of gated banks reaches a programmable cap or when every candidate has been tried. The interval length, the bank count and the degradation ratio are parameters. The defaults are 2,000,000 cycles, 12 banks and 103/100.

Top module: `bank_gate_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, every bit of `bank_en` is 1, every bit of `shadow_off` is 0 and `gate_pulse` is 0.
- R2: The first interval after reset is a baseline interval. No shadow bit is set during it, and it stores the number of `real_miss` cycles it contained. At its end, `shadow_off` becomes bit 0 alone, unless `max_off` is 0.
- R3: At the end of a trial interval for bank k, the bank passes when S×100 < B×103. Here S is the number of `shadow_miss` cycles in that interval and B is the baseline. The comparison is strict, so B = 0 never passes. A passing bank gets `bank_en[k]`=0 and its `shadow_off[k]` stays 1.
- R4: A candidate that fails gets `shadow_off[k]` cleared back to 0, and `bank_en[k]` stays 1.
- R5: Candidates are tried in ascending index order, one per interval. The next candidate's shadow bit is set in the same cycle in which the previous decision is recorded. At most one bank at a time has its shadow bit set while still being enabled.
- R6: The number of gated banks never exceeds `max_off`. When the cap is reached, or after the last index has been tried, no further shadow bit is set and both masks hold until reset.
- R7: `gate_pulse` is high for exactly one cycle, on the bit of the bank just gated, in the cycle in which that `bank_en` bit first reads 0.
- R8: `bank_en` changes only in the cycle that follows an interval's last cycle, and a gated bank is never re-enabled before reset.
- R9: Only `shadow_miss` counts during trial intervals; `real_miss` then has no effect. Miss counts restart from zero with every interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| real_miss | input | 1 | One miss from the real tag path in this cycle |
| shadow_miss | input | 1 | One miss from the shadow tag path in this cycle |
| max_off | input | $clog2(NUM_BANKS+1) | Cap on the number of banks gated at once |
| shadow_off | output | NUM_BANKS | Per-bank shadow tag disable (gating bit) |
| bank_en | output | NUM_BANKS | Per-bank real enable, 1 = powered |
| gate_pulse | output | NUM_BANKS | One-cycle notice for each newly gated bank |

## Verification
The bench drives trials with shadow counts right at the threshold. Against a baseline of 30, a count of 30 must gate the bank and a count of 31 must not. A design with a non-strict comparison, or with the ratio reversed, would flip those outcomes. Real misses are injected during a trial, and a controller that mixed the two paths would then refuse a bank that should pass. A zero baseline is tried, where a design that treats an equal count as passing would gate a bank it must keep. Caps of 0 and 2 are also tried; a design that checks the cap late would start an extra experiment or gate a bank too many, and that shows in both masks during the intervals that follow.

// File: rtl/bank_gate_pkg.sv
package bank_gate_pkg;
    typedef enum logic [1:0] {
        ST_BASE  = 2'd0,
        ST_TRIAL = 2'd1,
        ST_DONE  = 2'd2
    } gate_state_e;
endpackage

// File: rtl/gate_interval_timer.sv
module gate_interval_timer #(
    parameter int INTERVAL_CYCLES = 2_000_000,
    localparam int TW = (INTERVAL_CYCLES > 1) ? $clog2(INTERVAL_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic last
);
    localparam logic [TW-1:0] LAST_VAL = TW'(INTERVAL_CYCLES - 1);

    logic [TW-1:0] tick_d, tick_q;

    always_comb begin
        tick_d = (tick_q == LAST_VAL) ? '0 : tick_q + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end

    assign last = (tick_q == LAST_VAL);
endmodule

// File: rtl/gate_event_counter.sv
module gate_event_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             clr,
    output logic [CNT_W-1:0] total
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    // total includes the event of the current cycle, so the last cycle counts
    assign total = cnt_q + CNT_W'(evt);

    always_comb begin
        cnt_d = clr ? '0 : total;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/gate_degrade_cmp.sv
module gate_degrade_cmp #(
    parameter int CNT_W    = 32,
    parameter int DEGR_NUM = 103,
    parameter int DEGR_DEN = 100,
    localparam int PROD_W  = CNT_W + 17
) (
    input  logic [CNT_W-1:0] trial_cnt,
    input  logic [CNT_W-1:0] base_cnt,
    output logic             pass
);
    logic [PROD_W-1:0] lhs, rhs;

    always_comb begin
        lhs  = PROD_W'(trial_cnt) * PROD_W'(DEGR_DEN);
        rhs  = PROD_W'(base_cnt)  * PROD_W'(DEGR_NUM);
        pass = (lhs < rhs);
    end
endmodule

// File: rtl/bank_gate_ctrl.sv
module bank_gate_ctrl
    import bank_gate_pkg::*;
#(
    parameter int NUM_BANKS       = 12,
    parameter int INTERVAL_CYCLES = 2_000_000,
    parameter int CNT_W           = 32,
    parameter int DEGR_NUM        = 103,
    parameter int DEGR_DEN        = 100,
    localparam int MAX_W          = $clog2(NUM_BANKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 real_miss,
    input  logic                 shadow_miss,
    input  logic [MAX_W-1:0]     max_off,
    output logic [NUM_BANKS-1:0] shadow_off,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic [NUM_BANKS-1:0] gate_pulse
);
    localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BANKS - 1);

    typedef struct packed {
        gate_state_e            state;
        logic [IDX_W-1:0]       cand;
        logic [CNT_W-1:0]       base;
        logic [NUM_BANKS-1:0]   shadow_off;
        logic [NUM_BANKS-1:0]   bank_en;
        logic [NUM_BANKS-1:0]   pulse;
        logic [MAX_W-1:0]       off_cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic             ivl_last;
    logic [CNT_W-1:0] real_total;
    logic [CNT_W-1:0] shadow_total;
    logic             trial_pass;
    logic [MAX_W-1:0] off_nxt;
    logic [IDX_W-1:0] idx_nxt;

    gate_interval_timer #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .last  (ivl_last)
    );

    gate_event_counter #(.CNT_W(CNT_W)) u_real_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (real_miss),
        .clr   (ivl_last),
        .total (real_total)
    );

    gate_event_counter #(.CNT_W(CNT_W)) u_shadow_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (shadow_miss),
        .clr   (ivl_last),
        .total (shadow_total)
    );

    gate_degrade_cmp #(
        .CNT_W    (CNT_W),
        .DEGR_NUM (DEGR_NUM),
        .DEGR_DEN (DEGR_DEN)
    ) u_cmp (
        .trial_cnt (shadow_total),
        .base_cnt  (r_q.base),
        .pass      (trial_pass)
    );

    always_comb begin
        r_d       = r_q;
        r_d.pulse = '0;
        off_nxt   = r_q.off_cnt;
        idx_nxt   = r_q.cand + IDX_W'(1);

        if (ivl_last) begin
            unique case (r_q.state)
                ST_BASE: begin
                    r_d.base = real_total;
                    if (max_off == '0) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.state         = ST_TRIAL;
                        r_d.cand          = '0;
                        r_d.shadow_off[0] = 1'b1;
                    end
                end
                ST_TRIAL: begin
                    if (trial_pass) begin
                        r_d.bank_en[r_q.cand] = 1'b0;
                        r_d.pulse[r_q.cand]   = 1'b1;
                        off_nxt               = r_q.off_cnt + MAX_W'(1);
                    end else begin
                        r_d.shadow_off[r_q.cand] = 1'b0;
                    end
                    r_d.off_cnt = off_nxt;
                    if ((off_nxt >= max_off) || (r_q.cand == LAST_IDX)) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.cand                = idx_nxt;
                        r_d.shadow_off[idx_nxt] = 1'b1;
                    end
                end
                default: begin
                    r_d.state = ST_DONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state      <= ST_BASE;
            r_q.cand       <= '0;
            r_q.base       <= '0;
            r_q.shadow_off <= '0;
            r_q.bank_en    <= '1;
            r_q.pulse      <= '0;
            r_q.off_cnt    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign shadow_off = r_q.shadow_off;
    assign bank_en    = r_q.bank_en;
    assign gate_pulse = r_q.pulse;
endmodule

// File: rtl/bank_gate_chk.sv
module bank_gate_chk #(
    parameter int NUM_BANKS = 12,
    parameter int MAX_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ivl_last,
    input logic [MAX_W-1:0]     max_off,
    input logic [NUM_BANKS-1:0] shadow_off,
    input logic [NUM_BANKS-1:0] bank_en,
    input logic [NUM_BANKS-1:0] gate_pulse
);
    // R5: only one experiment at a time
    assert_single_trial_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(shadow_off & bank_en) <= 1);

    // R6: cap on gated banks
    assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bank_en) <= int'(max_off));

    // R7: notice matches the falling enable bits
    assert_pulse_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_pulse == ($past(bank_en) & ~bank_en));

    // R7: at most one bank announced per cycle
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_pulse));

    // R8: enables move only after an interval's last cycle
    assert_boundary_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ivl_last |=> $stable(bank_en));

    // R8: no re-enable before reset
    assert_no_reenable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (~$past(bank_en) & bank_en) == '0);
endmodule

bind bank_gate_ctrl bank_gate_chk #(
    .NUM_BANKS (NUM_BANKS),
    .MAX_W     (MAX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ivl_last   (ivl_last),
    .max_off    (max_off),
    .shadow_off (shadow_off),
    .bank_en    (bank_en),
    .gate_pulse (gate_pulse)
);

// File: tb/sim_bank_gate_ctrl.sv
module sim_bank_gate_ctrl;
    localparam int NB  = 12;
    localparam int IVL = 40;
    localparam int MW  = $clog2(NB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          real_miss = 1'b0;
    logic          shadow_miss = 1'b0;
    logic [MW-1:0] max_off = '0;
    logic [NB-1:0] shadow_off, bank_en, gate_pulse;

    int compared = 0;
    int mismatched = 0;
    logic [NB-1:0] pulse_next;

    always #2 clk = ~clk;

    bank_gate_ctrl #(
        .NUM_BANKS       (NB),
        .INTERVAL_CYCLES (IVL),
        .CNT_W           (16)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .real_miss   (real_miss),
        .shadow_miss (shadow_miss),
        .max_off     (max_off),
        .shadow_off  (shadow_off),
        .bank_en     (bank_en),
        .gate_pulse  (gate_pulse)
    );

    // per trial: real misses, shadow misses, expected pass (baseline 30)
    localparam int TBL [12][3] = '{
        '{0, 30, 1}, '{0, 31, 0}, '{35, 0, 1}, '{0, 29, 1},
        '{0, 40, 0}, '{0, 31, 0}, '{0, 1, 1},  '{0, 30, 1},
        '{0, 33, 0}, '{0, 0, 1},  '{0, 31, 0}, '{0, 12, 1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [MW-1:0] cap);
        rst_n   = 1'b0;
        max_off = cap;
        real_miss = 1'b0;
        shadow_miss = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // one full interval; pulse_next records gate_pulse one cycle in
    task automatic run_ivl(input int rn, input int sn);
        for (int i = 0; i < IVL; i++) begin
            real_miss   = (i < rn);
            shadow_miss = (i < sn);
            @(posedge clk);
            #1;
            if (i == 0) pulse_next = gate_pulse;
        end
        real_miss   = 1'b0;
        shadow_miss = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [NB-1:0] exp_en, exp_sh;
        int gated;

        // ---- table-driven sweep, cap 12
        do_reset(MW'(12));
        chk("R1 bank_en reset", 32'(bank_en), 32'(12'hFFF));
        chk("R1 shadow_off reset", 32'(shadow_off), 0);
        chk("R1 pulse reset", 32'(gate_pulse), 0);
        run_ivl(30, 5);  // baseline 30, shadow ignored
        chk("R2 baseline shadow bit0", 32'(shadow_off), 1);
        chk("R2 baseline banks on", 32'(bank_en), 32'(12'hFFF));
        exp_en = '1;
        exp_sh = 12'h001;
        for (int k = 0; k < 12; k++) begin
            logic [NB-1:0] exp_p;
            run_ivl(TBL[k][0], TBL[k][1]);
            exp_p = '0;
            if (TBL[k][2] == 1) begin
                exp_en[k] = 1'b0;
                exp_p[k]  = 1'b1;
            end else begin
                exp_sh[k] = 1'b0;
            end
            if (k < 11) exp_sh[k+1] = 1'b1;
            chk(TBL[k][2] == 1 ? "R3 pass gates bank" : "R4 fail keeps bank", 32'(bank_en), 32'(exp_en));
            chk("R5 shadow mask order", 32'(shadow_off), 32'(exp_sh));
            chk("R7 pulse on gated bank", 32'(gate_pulse), 32'(exp_p));
            if (k > 0) chk("R7 pulse lasts one cycle", 32'(pulse_next), 0);
        end
        chk("R9 real misses ignored in trial (bank2)", 32'(bank_en[2]), 0);
        run_ivl(40, 40);
        chk("R8 masks hold after last index", 32'(bank_en), 32'(exp_en));
        chk("R6 no trial after last index", 32'(shadow_off), 32'(exp_sh));
        chk("R7 no pulse when done", 32'(gate_pulse), 0);

        // ---- cap of 2
        do_reset(MW'(2));
        run_ivl(10, 0);
        gated = 0;
        for (int k = 0; k < 4; k++) begin
            run_ivl(0, 0);
            if (gated < 2) gated++;
        end
        chk("R6 cap two banks off", 32'(bank_en), 32'(12'hFFC));
        chk("R6 cap no further shadow", 32'(shadow_off), 32'(12'h003));
        chk("R6 cap count", gated, 2);

        // ---- zero baseline: equal counts must not pass
        do_reset(MW'(3));
        run_ivl(0, 0);
        run_ivl(0, 0);
        chk("R3 zero baseline keeps bank", 32'(bank_en), 32'(12'hFFF));
        chk("R4 shadow restored, next tried", 32'(shadow_off), 32'(12'h002));

        // ---- counts restart per interval: 20 then 20 real, baseline is 20
        do_reset(MW'(1));
        run_ivl(20, 0);
        run_ivl(0, 21);  // 2100 < 2060 false
        chk("R9 counter restart fail", 32'(bank_en), 32'(12'hFFF));
        run_ivl(0, 20);  // 2000 < 2060
        chk("R9 bank1 gated", 32'(bank_en), 32'(12'hFFD));
        chk("R6 cap one reached", 32'(shadow_off), 32'(12'h002));

        // ---- cap of zero
        do_reset(MW'(0));
        run_ivl(10, 0);
        chk("R2 cap zero no experiment", 32'(shadow_off), 0);
        run_ivl(0, 0);
        chk("R6 cap zero all banks on", 32'(bank_en), 32'(12'hFFF));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule